// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This unit builds an 8-byte result in which every byte is picked from a small table by its own index byte. The table is made of one to four 128-bit registers that sit next to each other in a 32-entry vector register file. The table starts at a register number given with the request. When the table runs past register 31, it continues at register 0. Any index that points beyond the end of the table leaves the matching byte of an initial vector in place.

The caller chooses that initial vector. It passes all zeros to get a lookup that clears missing bytes. It passes the old destination value to get a lookup that keeps them.

A request is taken with a valid/ready handshake. The unit then reads the table registers through a synchronous read port, one register per cycle, starting with the first table register. It merges the bytes of each register into the result as that register's data arrives. After the last merge it raises a one-cycle result strobe. The latency depends only on the table length, not on which registers the indices touch.

Top module: `vtl_lookup`

## Requirements
- R1: After reset, resValid is 0, reqReady is 1, rfRdEn is 0 and result is all zeros.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both 1. With count = reqCntM1 + 1 (so reqCntM1 = 0..3 means 1..4 registers), reqReady stays 0 from the cycle after acceptance until resValid rises. resValid is 1 in the cycle that follows the (count+1)-th clock edge after the accepting edge, and reqReady is 1 again in that same cycle.
- R3: In the count cycles that directly follow acceptance, rfRdEn is 1 and rfAddr takes the values start, start+1, and so on, one per cycle. The data for each address must be on rfData in the cycle after it is requested. rfRdEn is 0 at all other times.
- R4: An index byte i with i < 16*count selects byte (i mod 16) of register (start + i/16) mod 32. Byte k of a register lies at rfData bits 8k+7:8k.
- R5: An index byte i with i >= 16*count leaves the matching reqInit byte unchanged in the result. This holds both when reqInit is all zeros and when it carries an old destination value.
- R6: The index byte at reqIdx bits 8b+7:8b decides only result bits 8b+7:8b, for b = 0..7. Any number of lanes may use the same index.
- R7: The register number is computed modulo 32, so a table that starts near register 31 goes on through register 0 and upwards, both in the read address order and in byte selection.
- R8: resValid is a one-cycle pulse. result holds its value from that pulse until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is presented |
| reqReady | output | 1 | The unit can accept a request |
| reqIdx | input | 64 | Eight index bytes, lane b in bits 8b+7:8b |
| reqStart | input | 5 | First table register |
| reqCntM1 | input | 2 | Table length in registers, minus one |
| reqInit | input | 64 | Initial result (zeros, or the old destination) |
| rfRdEn | output | 1 | Register file read request |
| rfAddr | output | 5 | Register file read address |
| rfData | input | 128 | Read data, valid the cycle after rfRdEn |
| resValid | output | 1 | One-cycle result strobe |
| result | output | 64 | Lookup result |

## Verification
The hardest case to reach is a table that wraps past register 31 while several lanes use indices on both sides of the wrap, with some indices just past the table end. In that case the read order, the choice of register half and the pass-through of out-of-range bytes all interact within one request. The stimulus sweeps every index value from 0 to 255 for each of the four table lengths. It moves the start register with each group of eight indices, so many starts close to 31 occur. It then adds directed requests that start at register 31 with four registers, that repeat indices across lanes, and that use a kept destination with every index out of range.

// File: rtl/vtl_pkg.sv
package vtl_pkg;
  // Table length field width; the table holds up to 2**SLOT_W registers.
  localparam int SLOT_W  = 2;
  localparam int MAX_TBL = 1 << SLOT_W;
  localparam int IDX_W   = 8;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic              load;    // capture a new request
    logic              merge;   // rfData carries table register 'slot'
    logic [SLOT_W-1:0] slot;    // table position of the register on rfData
    logic              finish;  // this merge is the last of the request
  } vtlStrobe_t;
endpackage

// File: rtl/vtl_ctrl.sv
module vtl_ctrl
  import vtl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqStart,
  input  logic [SLOT_W-1:0] reqCntM1,
  output logic              reqReady,
  output logic              rfRdEn,
  output logic [ADDR_W-1:0] rfAddr,
  output vtlStrobe_t        strb
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_DRAIN} state_t;

  state_t            state;
  logic [ADDR_W-1:0] startLat;
  logic [SLOT_W-1:0] cntLat;
  logic [SLOT_W-1:0] rdSlot;
  logic [SLOT_W-1:0] dataSlot;
  logic              dataVld;
  logic              accept;

  assign reqReady = (state == S_IDLE);
  assign accept   = reqValid & reqReady;
  assign rfRdEn   = (state == S_READ);
  // Modulo-32 wrap falls out of the ADDR_W-bit add.
  assign rfAddr   = startLat + ADDR_W'(rdSlot);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      startLat <= '0;
      cntLat   <= '0;
      rdSlot   <= '0;
      dataSlot <= '0;
      dataVld  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          dataVld <= 1'b0;
          if (accept) begin
            startLat <= reqStart;
            cntLat   <= reqCntM1;
            rdSlot   <= '0;
            state    <= S_READ;
          end
        end
        S_READ: begin
          dataVld  <= 1'b1;
          dataSlot <= rdSlot;
          if (rdSlot == cntLat) state <= S_DRAIN;
          else                  rdSlot <= rdSlot + 1'b1;
        end
        S_DRAIN: begin
          dataVld <= 1'b0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load   = accept;
    strb.merge  = dataVld;
    strb.slot   = dataSlot;
    strb.finish = dataVld && (dataSlot == cntLat);
  end

  // Read counter kept only for checking the number of reads per request.
  logic [SLOT_W:0] rdCount;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rdCount <= '0;
    else if (accept) rdCount <= '0;
    else if (rfRdEn) rdCount <= rdCount + 1'b1;
  end

  p_first_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (rfRdEn && rfAddr == $past(reqStart)));

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rfRdEn && $past(rfRdEn)) |-> (rfAddr == ADDR_W'($past(rfAddr) + 1'b1)));

  p_read_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rfRdEn) |-> (rdCount == ({1'b0, cntLat} + 1'b1)));
endmodule

// File: rtl/vtl_dp.sv
module vtl_dp
  import vtl_pkg::*;
#(
  parameter int LANES = 8,
  parameter int REG_W = 128
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  vtlStrobe_t             strb,
  input  logic [LANES*IDX_W-1:0] reqIdx,
  input  logic [LANES*8-1:0]     reqInit,
  input  logic [SLOT_W-1:0]      reqCntM1,
  input  logic [REG_W-1:0]       rfData,
  output logic [LANES*8-1:0]     result,
  output logic                   resValid
);
  localparam int BYTES_PER_REG = REG_W / 8;
  localparam int OFS_W         = $clog2(BYTES_PER_REG);

  logic [LANES*IDX_W-1:0] idxLat;
  logic [SLOT_W-1:0]      cntLat;
  logic [LANES*8-1:0]     accNext;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] laneIdx;
    logic             inTbl;
    logic             hit;
    assign laneIdx = idxLat[g*IDX_W +: IDX_W];
    // Register position inside the table: bits above the byte offset.
    assign inTbl   = (laneIdx >> OFS_W) <= IDX_W'(cntLat);
    assign hit     = strb.merge && inTbl && (laneIdx[OFS_W +: SLOT_W] == strb.slot);
    assign accNext[g*8 +: 8] =
      strb.load ? reqInit[g*8 +: 8] :
      hit       ? rfData[{laneIdx[OFS_W-1:0], 3'b000} +: 8] :
                  result[g*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxLat   <= '0;
      cntLat   <= '0;
      result   <= '0;
      resValid <= 1'b0;
    end else begin
      if (strb.load) begin
        idxLat <= reqIdx;
        cntLat <= reqCntM1;
      end
      result   <= accNext;
      resValid <= strb.finish;
    end
  end

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.merge) |=> $stable(result));
endmodule

// File: rtl/vtl_lookup.sv
module vtl_lookup
  import vtl_pkg::*;
#(
  parameter int LANES = 8,
  parameter int REG_W = 128,
  parameter int NREGS = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [LANES*IDX_W-1:0]        reqIdx,
  input  logic [$clog2(NREGS)-1:0]      reqStart,
  input  logic [SLOT_W-1:0]             reqCntM1,
  input  logic [LANES*8-1:0]            reqInit,
  output logic                          rfRdEn,
  output logic [$clog2(NREGS)-1:0]      rfAddr,
  input  logic [REG_W-1:0]              rfData,
  output logic                          resValid,
  output logic [LANES*8-1:0]            result
);
  localparam int ADDR_W = $clog2(NREGS);

  vtlStrobe_t strb;

  vtl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqStart (reqStart),
    .reqCntM1 (reqCntM1),
    .reqReady (reqReady),
    .rfRdEn   (rfRdEn),
    .rfAddr   (rfAddr),
    .strb     (strb)
  );

  vtl_dp #(.LANES(LANES), .REG_W(REG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqIdx   (reqIdx),
    .reqInit  (reqInit),
    .reqCntM1 (reqCntM1),
    .rfData   (rfData),
    .result   (result),
    .resValid (resValid)
  );
endmodule

// File: tb/sim_vtl_lookup.sv
`timescale 1ns/1ps
module sim_vtl_lookup;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [63:0]  reqIdx = '0;
  logic [4:0]   reqStart = '0;
  logic [1:0]   reqCntM1 = '0;
  logic [63:0]  reqInit = '0;
  logic         rfRdEn;
  logic [4:0]   rfAddr;
  logic [127:0] rfData = '0;
  logic         resValid;
  logic [63:0]  result;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  logic [127:0] mem [32];

  always #10 clk = ~clk;  // 50 MHz

  vtl_lookup u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIdx(reqIdx), .reqStart(reqStart), .reqCntM1(reqCntM1), .reqInit(reqInit),
    .rfRdEn(rfRdEn), .rfAddr(rfAddr), .rfData(rfData),
    .resValid(resValid), .result(result)
  );

  // Behavioural register file with a one-cycle read.
  always @(posedge clk) if (rfRdEn) rfData <= mem[rfAddr];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nFails++;
      $display("FAIL R2 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] refLookup(logic [63:0] idx, int start, int cnt, logic [63:0] init);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) begin
      int i;
      i = int'(idx[b*8 +: 8]);
      if (i < 16 * cnt) r[b*8 +: 8] = mem[(start + i / 16) % 32][(i % 16) * 8 +: 8];
      else              r[b*8 +: 8] = init[b*8 +: 8];
    end
    return r;
  endfunction

  // Issue one request at a negedge and follow it cycle by cycle.
  task automatic doReq(input logic [63:0] idx, input int start, input int cnt,
                       input logic [63:0] init, input string tag);
    logic [63:0] exp;
    exp = refLookup(idx, start, cnt, init);
    chk(reqReady == 1'b1, "R2 ready before request", 64'(reqReady), 64'd1);
    reqIdx = idx; reqStart = 5'(start); reqCntM1 = 2'(cnt - 1); reqInit = init;
    reqValid = 1'b1;
    for (int n = 1; n <= cnt + 2; n++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (n <= cnt) begin
        chk(rfRdEn == 1'b1, "R3 read enable", 64'(rfRdEn), 64'd1);
        chk(rfAddr == 5'((start + n - 1) % 32), "R3 R7 read address", 64'(rfAddr), 64'((start + n - 1) % 32));
      end else begin
        chk(rfRdEn == 1'b0, "R3 no extra read", 64'(rfRdEn), 64'd0);
      end
      chk(resValid == (n == cnt + 2), "R2 R8 result strobe timing", 64'(resValid), 64'(n == cnt + 2));
      chk(reqReady == (n == cnt + 2), "R2 ready timing", 64'(reqReady), 64'(n == cnt + 2));
    end
    chk(result == exp, tag, result, exp);
  endtask

  initial begin
    logic [63:0] held;
    for (int r = 0; r < 32; r++)
      for (int j = 0; j < 16; j++)
        mem[r][j*8 +: 8] = 8'((r * 37 + j * 11 + 3) ^ (r << 4));

    repeat (3) @(negedge clk);
    // R1: reset values
    chk(resValid == 1'b0, "R1 resValid", 64'(resValid), 64'd0);
    chk(reqReady == 1'b1, "R1 reqReady", 64'(reqReady), 64'd1);
    chk(rfRdEn == 1'b0,   "R1 rfRdEn", 64'(rfRdEn), 64'd0);
    chk(result == 64'd0,  "R1 result", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 R5 R6: every index value for every table length, starts sweeping through 31.
    for (int cnt = 1; cnt <= 4; cnt++) begin
      for (int base = 0; base < 256; base += 8) begin
        logic [63:0] idx;
        logic [63:0] init;
        for (int b = 0; b < 8; b++) idx[b*8 +: 8] = 8'(base + 7 - b);
        init = ((base / 8) % 2 == 0) ? 64'd0 : (64'hC3A5_1E0F_7788_9B2D ^ 64'(base));
        doReq(idx, (base / 8 + cnt * 7) % 32, cnt, init, "R4 R5 R6 exhaustive lookup");
      end
    end

    // R7: start at the last register, four registers, indices on both sides of the wrap.
    doReq(64'h3F30_2F20_1F10_0F00, 31, 4, 64'd0, "R7 wrap from 31 to 0");
    doReq(64'h2A1B_0C3D_FF40_2F11, 30, 3, 64'h1111_2222_3333_4444, "R7 wrap with out-of-range");

    // R6: repeated indices across lanes, mixed in and out of range.
    doReq(64'hFF10_1005_403F_0005, 9, 2, 64'hA1A2_A3A4_A5A6_A7A8, "R6 repeated indices");

    // R5: keep variant, every index out of range.
    doReq(64'hC010_4050_8011_FF20, 4, 1, 64'hDEAD_BEEF_0123_4567, "R5 all out of range keeps old");
    held = result;

    // R8: result held while idle.
    repeat (4) @(negedge clk);
    chk(result == held, "R8 result held while idle", result, held);
    chk(resValid == 1'b0, "R8 strobe is a pulse", 64'(resValid), 64'd0);

    // Boundary: index 15 valid, index 16 invalid for one register.
    doReq(64'h0F10_0F10_0F10_0F10, 0, 1, 64'h5555_5555_5555_5555, "R4 R5 table end boundary");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule